// File: doc/BRIEF.md
# GPIO Port with Interrupt Detection

This block is a 32-pin general-purpose I/O port. A small register interface sets each pin's output enable, input enable and output data, and reads back the level of each pin. A pin acts as an output when its output enable is set. It acts as an input only when its input enable is set and its output enable is clear. A pin with both enables clear is disconnected.

Each input pin has an interrupt detector. The detector samples the pad through a two-flop synchroniser and compares each sample with the previous one. It recognises four trigger types: high level, low level, rising edge and falling edge. Each pin takes its type from a 2-bit field. A detected event sets that pin's pending bit. A per-pin mask selects which pending bits reach the single interrupt line, and a port enable gates that line.

A port-level pending flag records that an event arrived on an unmasked pin. Both the per-pin pending bits and the port-level flag are cleared by writing 1. A sample-select bit picks one of two sampling rates: every clock, or every `SLOW_DIV` clocks.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, every register reads 0, `pad_oe` is 0 and `irq` is 0.
- R2: `pad_oe` equals the output-enable register (word 0), and `pad_out` equals the data register (word 2).
- R3: Reading word 2 returns the following per pin:
  - for an output pin, the written data bit;
  - for an input pin (word 1 bit set, word 0 bit clear), the synchronised pad level;
  - for a disconnected pin, 0.
- R4: Pin p takes its trigger field from bits (p mod 16)*2+1:(p mod 16)*2. For p below 16 the field is in word 4; otherwise it is in word 3. The encodings are 00 high level, 01 low level, 10 rising edge and 11 falling edge.
- R5: An edge-type pin sets its pending bit (word 6) once per matching pad transition. A pending bit never rises without a detected event.
- R6: A level-type pin sets its pending bit again after a write-1 clear, for as long as its level condition holds.
- R7: Writing 1 to a bit of word 6 clears that bit unless a new event arrives in the same cycle. Writing 0 leaves the bit unchanged.
- R8: A pin that is not an input (output enabled, or input disabled) never sets its pending bit.
- R9: `irq` is high exactly when the port enable (word 7, bit CTL_IDX*5) is set and some pending bit has its mask bit (word 5) set.
- R10: The port pending flag (word 7, bit CTL_IDX*5+1) sets when an event arrives on an unmasked pin. It is cleared by writing 1 and is unchanged by writing 0. An event on a masked pin does not set it.
- R11: When the sample-select bit (word 7, bit CTL_IDX*5+2) is set, pads are sampled once every SLOW_DIV clocks, and edge events are still detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data for the word at `bus_addr` (combinational) |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output data |
| pad_oe | output | NPINS | Pad output enables |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench sweeps every pin against every trigger type.
- For each combination, the other pins are held on an edge type that stays quiet, so that any crosstalk between fields or pins shows up as an extra pending bit.
- Toggling the pin under test separates edge types from level types. After a clear, an edge type stays clear, while a level type sets again.
- The same pattern on output pins and on disconnected pins must produce nothing.
- Separate mask, enable and clear sequences tell the per-pin pending bits apart from the port flag and from the interrupt line.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'b00,
    TRIG_LOW  = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_e;

  // register word indices
  localparam logic [2:0] W_OEN = 3'd0;
  localparam logic [2:0] W_IEN = 3'd1;
  localparam logic [2:0] W_DAT = 3'd2;
  localparam logic [2:0] W_TYH = 3'd3;  // upper-half pins
  localparam logic [2:0] W_TYL = 3'd4;  // lower-half pins
  localparam logic [2:0] W_MSK = 3'd5;
  localparam logic [2:0] W_PND = 3'd6;
  localparam logic [2:0] W_CTL = 3'd7;

  // Trigger field of one pin, chosen from the two type words.
  function automatic trig_e pick_trig(input logic [31:0] lo_word,
                                      input logic [31:0] hi_word,
                                      input int pin, input int half);
    logic [31:0] w;
    int sh;
    w  = (pin < half) ? lo_word : hi_word;
    sh = (pin % half) * 2;
    return trig_e'(w[sh +: 2]);
  endfunction

  // Event condition for one sample, given current and previous level.
  function automatic logic trig_hit(input trig_e t, input logic cur,
                                    input logic prv);
    case (t)
      TRIG_HIGH: return cur;
      TRIG_LOW:  return !cur;
      TRIG_RISE: return cur && !prv;
      default:   return !cur && prv;
    endcase
  endfunction

endpackage

// File: rtl/gpio_pad_sync.sv
module gpio_pad_sync #(
  parameter int NPINS    = 32,
  parameter int SLOW_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pad_in,
  input  logic             slow_sel,
  output logic [NPINS-1:0] lvl,
  output logic [NPINS-1:0] prv,
  output logic             strobe
);
  localparam int CW = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] CMAX = CW'(SLOW_DIV - 1);

  logic [NPINS-1:0] meta;
  logic [CW-1:0]    cnt;

  assign strobe = !slow_sel || (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta <= '0;
      lvl  <= '0;
      prv  <= '0;
      cnt  <= '0;
    end else begin
      meta <= pad_in;
      lvl  <= meta;
      cnt  <= (cnt == CMAX) ? '0 : cnt + 1'b1;
      if (strobe) prv <= lvl;
    end
  end

  // R11
  slow_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slow_sel && strobe) |=> !strobe || !slow_sel);
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] lvl,
  input  logic [NPINS-1:0] prv,
  input  logic             strobe,
  input  logic [NPINS-1:0] is_in,
  input  logic [NPINS-1:0] typ_lo,
  input  logic [NPINS-1:0] typ_hi,
  output logic [NPINS-1:0] evt
);
  localparam int HALF = NPINS / 2;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign evt[i] = strobe && is_in[i] &&
                    trig_hit(pick_trig(typ_lo, typ_hi, i, HALF), lvl[i], prv[i]);
  end

  // R8
  non_input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~is_in) == '0);
endmodule

// File: rtl/gpio_pend.sv
module gpio_pend #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] evt,
  input  logic             clr_we,
  input  logic [NPINS-1:0] clr_data,
  output logic [NPINS-1:0] pend
);
  logic [NPINS-1:0] clr_mask;
  assign clr_mask = clr_we ? clr_data : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_mask) | evt;
  end

  // R5
  no_spurious_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(evt)) == '0));

  // R7
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((pend & $past(clr_data & ~evt)) == '0));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter int SLOW_DIV = 4,
  parameter int CTL_IDX  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic             irq
);
  localparam int CB = CTL_IDX * 5;  // control group base bit

  logic [NPINS-1:0] oen, ien, dat, typ_hi, typ_lo, msk;
  logic             ctl_en, ctl_pend, ctl_sel;
  logic [NPINS-1:0] lvl, prv, is_in, evt, pend, pin_lvl, ctl_word;
  logic             strobe, port_evt, ctl_clr;

  assign is_in    = ien & ~oen;
  assign pin_lvl  = (oen & dat) | (is_in & lvl);
  assign port_evt = |(evt & msk);
  assign ctl_clr  = bus_we && (bus_addr == W_CTL) && bus_wdata[CB+1];
  assign pad_oe   = oen;
  assign pad_out  = dat;
  assign irq      = ctl_en && |(pend & msk);

  always_comb begin
    ctl_word         = '0;
    ctl_word[CB]     = ctl_en;
    ctl_word[CB+1]   = ctl_pend;
    ctl_word[CB+2]   = ctl_sel;
  end

  always_comb begin
    case (bus_addr)
      W_OEN:   bus_rdata = oen;
      W_IEN:   bus_rdata = ien;
      W_DAT:   bus_rdata = pin_lvl;
      W_TYH:   bus_rdata = typ_hi;
      W_TYL:   bus_rdata = typ_lo;
      W_MSK:   bus_rdata = msk;
      W_PND:   bus_rdata = pend;
      default: bus_rdata = ctl_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oen <= '0; ien <= '0; dat <= '0;
      typ_hi <= '0; typ_lo <= '0; msk <= '0;
      ctl_en <= 1'b0; ctl_sel <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        W_OEN: oen    <= bus_wdata;
        W_IEN: ien    <= bus_wdata;
        W_DAT: dat    <= bus_wdata;
        W_TYH: typ_hi <= bus_wdata;
        W_TYL: typ_lo <= bus_wdata;
        W_MSK: msk    <= bus_wdata;
        W_CTL: begin
          ctl_en  <= bus_wdata[CB];
          ctl_sel <= bus_wdata[CB+2];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl_pend <= 1'b0;
    else        ctl_pend <= (ctl_pend && !ctl_clr) || port_evt;
  end

  gpio_pad_sync #(.NPINS(NPINS), .SLOW_DIV(SLOW_DIV)) u_sync (
    .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .slow_sel(ctl_sel),
    .lvl(lvl), .prv(prv), .strobe(strobe));

  gpio_trig_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .prv(prv), .strobe(strobe),
    .is_in(is_in), .typ_lo(typ_lo), .typ_hi(typ_hi), .evt(evt));

  gpio_pend #(.NPINS(NPINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .evt(evt),
    .clr_we(bus_we && (bus_addr == W_PND)), .clr_data(bus_wdata),
    .pend(pend));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq && pad_oe == '0 && pend == '0));

  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |-> !irq);

  // R10
  port_pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_pend) |-> $past(port_evt));
endmodule

// File: tb/gpio_irq_port_tb.sv
module gpio_irq_port_tb;
  localparam int N = 32;
  localparam time TCK = 20ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_we = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata, pad_out, pad_oe;
  logic [N-1:0] pad_in = '0;
  logic         irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(TCK/2) clk = ~clk;

  gpio_irq_port u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq));

  task automatic check(input string tag, input logic [N-1:0] got,
                       input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%08h exp=%08h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [N-1:0] v, lo_w, hi_w, exp_pad;

  initial begin
    #(TCK * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check($sformatf("R1 word%0d", a), v, '0);
    end
    check("R1 pad_oe", pad_oe, '0);
    check("R1 irq", {31'b0, irq}, '0);

    // R2: pad drive
    wr(3'd0, 32'hA5A5_0F0F);
    wr(3'd2, 32'h1234_5678);
    check("R2 pad_oe", pad_oe, 32'hA5A5_0F0F);
    check("R2 pad_out", pad_out, 32'h1234_5678);

    // R3: pin level readback, outputs win over inputs
    wr(3'd0, 32'h0000_FFFF);
    wr(3'd1, 32'hFF00_00FF);
    pad_in = 32'hCAFE_BEEF;
    idle(4);
    rd(3'd2, v);
    exp_pad = (32'h1234_5678 & 32'h0000_FFFF) |
              (32'hCAFE_BEEF & 32'hFF00_00FF & ~32'h0000_FFFF);
    check("R3 readback", v, exp_pad);
    pad_in = '0;
    wr(3'd0, '0);
    wr(3'd1, 32'hFFFF_FFFF);
    idle(4);

    // R4 R5 R6: every pin against every trigger type
    for (int p = 0; p < N; p++) begin
      for (int t = 0; t < 4; t++) begin
        logic start_hi;
        start_hi = (t == 1) || (t == 3);
        pad_in[p] = start_hi;
        idle(4);
        lo_w = '0; hi_w = '0;
        for (int q = 0; q < N; q++) begin
          logic [1:0] f;
          f = (q == p) ? 2'(t) : 2'b10;
          if (q < 16) lo_w[2*q +: 2] = f;
          else        hi_w[2*(q-16) +: 2] = f;
        end
        wr(3'd4, lo_w);
        wr(3'd3, hi_w);
        wr(3'd6, 32'hFFFF_FFFF);
        idle(4);
        rd(3'd6, v);
        check($sformatf("R4 quiet p%0d t%0d", p, t), v, '0);
        pad_in[p] = ~start_hi;
        idle(5);
        rd(3'd6, v);
        check($sformatf("R5 event p%0d t%0d", p, t), v, 32'(1) << p);
        wr(3'd6, 32'(1) << p);
        idle(4);
        rd(3'd6, v);
        if (t < 2) check($sformatf("R6 level reset p%0d t%0d", p, t), v, 32'(1) << p);
        else       check($sformatf("R5 once p%0d t%0d", p, t), v, '0);
        pad_in[p] = 1'b0;
        idle(4);
        wr(3'd4, 32'hAAAA_AAAA);
        wr(3'd3, 32'hAAAA_AAAA);
        wr(3'd6, 32'hFFFF_FFFF);
        idle(2);
      end
    end

    // R7: writing 0 leaves pending bits
    pad_in[7] = 1'b1;
    idle(5);
    wr(3'd6, 32'h0000_0000);
    rd(3'd6, v);
    check("R7 write0 keeps", v, 32'h0000_0080);
    wr(3'd6, 32'h0000_0080);
    rd(3'd6, v);
    check("R7 write1 clears", v, '0);
    pad_in[7] = 1'b0;
    idle(4);

    // R8: output pin and disconnected pin stay quiet
    wr(3'd0, 32'h0000_0008);
    pad_in[3] = 1'b1;
    idle(5);
    rd(3'd6, v);
    check("R8 output pin", v, '0);
    pad_in[3] = 1'b0;
    wr(3'd0, '0);
    wr(3'd1, 32'hFFFF_FFF7);
    pad_in[3] = 1'b1;
    idle(5);
    rd(3'd6, v);
    check("R8 disconnected pin", v, '0);
    pad_in[3] = 1'b0;
    wr(3'd1, 32'hFFFF_FFFF);
    idle(4);

    // R9 R10: mask, enable, port flag (masked event first)
    pad_in[20] = 1'b1;
    idle(5);
    rd(3'd7, v);
    check("R10 masked no flag", v, '0);
    check("R9 disabled irq", {31'b0, irq}, '0);
    wr(3'd7, 32'h0000_0001);
    check("R9 masked irq", {31'b0, irq}, '0);
    wr(3'd5, 32'h0010_0000);
    check("R9 irq on", {31'b0, irq}, 32'd1);
    wr(3'd7, 32'h0000_0000);
    check("R9 enable off", {31'b0, irq}, '0);
    wr(3'd7, 32'h0000_0001);
    wr(3'd6, 32'h0010_0000);
    check("R9 cleared irq", {31'b0, irq}, '0);
    pad_in[20] = 1'b0;
    idle(4);
    pad_in[20] = 1'b1;
    idle(5);
    rd(3'd7, v);
    check("R10 flag set", v, 32'h0000_0003);
    wr(3'd7, 32'h0000_0001);
    rd(3'd7, v);
    check("R10 write0 keeps", v, 32'h0000_0003);
    wr(3'd7, 32'h0000_0003);
    rd(3'd7, v);
    check("R10 write1 clears", v, 32'h0000_0001);
    pad_in[20] = 1'b0;
    wr(3'd6, 32'hFFFF_FFFF);
    idle(4);

    // R11: slow sampling still sees an edge
    wr(3'd7, 32'h0000_0005);
    wr(3'd6, 32'hFFFF_FFFF);
    pad_in[20] = 1'b1;
    idle(10);
    rd(3'd6, v);
    check("R11 slow edge", v, 32'h0010_0000);
    check("R11 slow irq", {31'b0, irq}, 32'd1);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule